// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register-and-memory half of a small microcoded accumulator machine. It holds an 8-bit program counter and memory address register, and five 12-bit registers: instruction, memory data, accumulator, B operand and ALU result. A 256-word by 12-bit main memory completes it. All transfers between registers use one shared 12-bit bus. An external sequencer sends a 16-bit control word on every clock. The datapath does everything that word asks within that single clock. It returns the opcode field of the instruction register and the sign of the accumulator so the sequencer can choose its next step.

Inside a cycle the work happens in a fixed order. Bus sources are applied first, then the memory access, then the ALU operation, then register loads, and the PC increment comes last. Because of this order, several cases are well defined:
- A memory access uses the address and data held at the start of the cycle.
- A value placed on the bus can be loaded in the same cycle.
- An increment can follow a PC load in the same cycle.

A preload port fills memory while the datapath is idle. A combinational peek port reads back any word after a program halts.

Top module: `sbus_datapath`

## Requirements
- R1: Synchronous active-high reset clears every register and every memory word. After reset, `opcode` is 0 and `acc_neg` is 0.
- R2: The control word `ctl_word` has the following bit positions: bit0 drive PC, bit1 drive MDR, bit2 drive IR, bit3 drive ACC, bit4 drive ALU register, bit5 memory read, bit6 memory write, bit7 add, bit8 subtract, bit9 load PC, bit10 load MAR, bit11 load MDR, bit12 load IR, bit13 load ACC, bit14 load B, bit15 increment PC.
- R3: The bus carries one source, chosen by priority: PC first, then MDR, then IR, then ACC, then the ALU register. PC and IR drive only 8 bits, with bus bits 11-8 set to zero. With no source bit set, the bus is zero. `bus_clash` is 1 in any cycle in which two or more source bits are set.
- R4: A bus value is loaded into its destination register in the same cycle in which it is driven. For example, driving MDR and loading ACC together moves MDR into ACC in one cycle.
- R5: A memory read places the word at the start-of-cycle MAR into MDR. If load MDR is set in the same cycle, the bus value wins.
- R6: A memory write stores the start-of-cycle MDR at the start-of-cycle MAR.
- R7: Add sets the ALU register to ACC+B, and subtract sets it to ACC−B. Both wrap modulo 4096. If both are set, subtract wins.
- R8: Loading PC or MAR takes bus bits 7-0.
- R9: The PC increment is applied after a PC load in the same cycle and wraps modulo 256.
- R10: `opcode` equals IR bits 11-8, and `acc_neg` equals ACC bit 11.
- R11: The preload port writes memory only in a cycle where `ctl_word` is all zero; otherwise the write is ignored. `peek_data` shows the memory word at `peek_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 16 | Register-transfer control bits for this cycle |
| pre_we | input | 1 | Preload write request |
| pre_addr | input | 8 | Preload address |
| pre_data | input | 12 | Preload data |
| peek_addr | input | 8 | Read-back address |
| peek_data | output | 12 | Memory word at `peek_addr` |
| opcode | output | 4 | IR bits 11-8 |
| acc_neg | output | 1 | ACC bit 11 |
| bus_clash | output | 1 | More than one bus source requested |

## Verification
The assertions assume that `ctl_word` changes only between clock edges and that preload requests occur only while the control word is zero. Under those assumptions, a memory write from the datapath never coincides with a preload. The bench drives every input on the falling edge and issues preloads only in idle cycles. It observes internal registers by copying them into MDR and writing them to a known address, which it then reads through the peek port. Contention is exercised only on purpose, in one cycle, to check both the priority and the flag.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int DATA_W = 12;
    localparam int ADDR_W = 8;

    // Control word, MSB first: bit15 inc ... bit0 drive PC
    typedef struct packed {
        logic inc;
        logic lb;
        logic la;
        logic li;
        logic ld;
        logic lm;
        logic lp;
        logic sub;
        logic add;
        logic wr;
        logic rd;
        logic eu;
        logic ea;
        logic ei;
        logic ed;
        logic ep;
    } ctl_t;

    // Bus source enables in priority order, index 0 highest
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_PC   = 3'd1,
        SRC_MDR  = 3'd2,
        SRC_IR   = 3'd3,
        SRC_ACC  = 3'd4,
        SRC_ALU  = 3'd5
    } bus_src_e;

    function automatic bus_src_e pick_src(input logic [4:0] en);
        bus_src_e s;
        s = SRC_NONE;
        for (int i = 4; i >= 0; i--) begin
            if (en[i]) s = bus_src_e'(i + 1);
        end
        return s;
    endfunction
endpackage

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux
    import sbus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic [4:0]    en,     // {alu, acc, ir, mdr, pc}
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] mdr,
    input  logic [DW-1:0] ir,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] alu,
    output logic [DW-1:0] bus,
    output logic          clash
);
    localparam int PADW = DW - AW;
    bus_src_e src;

    always_comb begin
        src = pick_src(en);
        unique case (src)
            SRC_PC:  bus = {{PADW{1'b0}}, pc};
            SRC_MDR: bus = mdr;
            SRC_IR:  bus = {{PADW{1'b0}}, ir[AW-1:0]};
            SRC_ACC: bus = acc;
            SRC_ALU: bus = alu;
            default: bus = '0;
        endcase
    end

    assign clash = ($countones(en) > 1);
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add,
    input  logic          sub,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] alu_q
);
    always_ff @(posedge clk) begin
        if (rst)      alu_q <= '0;
        else if (sub) alu_q <= acc - b;
        else if (add) alu_q <= acc + b;
    end

    // R7
    alu_sub_chk: assert property (@(posedge clk) disable iff (rst)
        sub |=> alu_q == $past(acc) - $past(b));
    // R7
    alu_add_chk: assert property (@(posedge clk) disable iff (rst)
        (add && !sub) |=> alu_q == $past(acc) + $past(b));
endmodule

// File: rtl/sbus_mem.sv
module sbus_mem
    import sbus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
    assign pdata = store[paddr];

    // R6
    mem_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> store[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [15:0]   ctl_word,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    output logic [DW-AW-1:0] opcode,
    output logic          acc_neg,
    output logic          bus_clash
);
    ctl_t c;
    logic idle;
    logic [AW-1:0] pc_q, mar_q, pc_n;
    logic [DW-1:0] mdr_q, ir_q, acc_q, b_q, alu_q, bus, rd_word, mdr_n;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;

    assign c    = ctl_t'(ctl_word);
    assign idle = (ctl_word == '0);

    // Phase 1: bus sources
    sbus_bus_mux #(.DW(DW), .AW(AW)) u_mux (
        .en    ({c.eu, c.ea, c.ei, c.ed, c.ep}),
        .pc    (pc_q),
        .mdr   (mdr_q),
        .ir    (ir_q),
        .acc   (acc_q),
        .alu   (alu_q),
        .bus   (bus),
        .clash (bus_clash)
    );

    // Phase 2: memory, using start-of-cycle MAR and MDR
    assign mem_we    = c.wr | (pre_we & idle);
    assign mem_waddr = c.wr ? mar_q : pre_addr;
    assign mem_wdata = c.wr ? mdr_q : pre_data;

    sbus_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mar_q),
        .rdata (rd_word),
        .paddr (peek_addr),
        .pdata (peek_data)
    );

    // Phase 3: ALU
    sbus_alu #(.DW(DW)) u_alu (
        .clk   (clk),
        .rst   (rst),
        .add   (c.add),
        .sub   (c.sub),
        .acc   (acc_q),
        .b     (b_q),
        .alu_q (alu_q)
    );

    // Phases 4 and 5: loads, then increment
    always_comb begin
        pc_n = c.lp ? bus[AW-1:0] : pc_q;
        if (c.inc) pc_n = pc_n + 1'b1;
        mdr_n = mdr_q;
        if (c.rd) mdr_n = rd_word;
        if (c.ld) mdr_n = bus;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            b_q   <= '0;
        end else begin
            pc_q  <= pc_n;
            mdr_q <= mdr_n;
            if (c.lm) mar_q <= bus[AW-1:0];
            if (c.li) ir_q  <= bus;
            if (c.la) acc_q <= bus;
            if (c.lb) b_q   <= bus;
        end
    end

    assign opcode  = ir_q[DW-1:AW];
    assign acc_neg = acc_q[DW-1];

    // R4
    acc_load_chk: assert property (@(posedge clk) disable iff (rst)
        c.la |=> acc_q == $past(bus));
    // R9
    pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (c.inc && !c.lp) |=> pc_q == $past(pc_q) + 1'b1);
    // R5
    mdr_read_chk: assert property (@(posedge clk) disable iff (rst)
        (c.rd && !c.ld) |=> mdr_q == $past(rd_word));
    // R3
    bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (c.lb && !c.ep && !c.ed && !c.ei && !c.ea && !c.eu) |=> b_q == '0);
endmodule

// File: tb/sbus_datapath_tb.sv
`timescale 1ns/1ps
module sbus_datapath_tb;
    localparam logic [15:0] EP = 16'h0001, ED = 16'h0002, EI = 16'h0004,
        EA = 16'h0008, EU = 16'h0010, RD = 16'h0020, WR = 16'h0040,
        ADD = 16'h0080, SUB = 16'h0100, LP = 16'h0200, LM = 16'h0400,
        LD = 16'h0800, LI = 16'h1000, LA = 16'h2000, LB = 16'h4000,
        INC = 16'h8000;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ctl_word;
    logic        pre_we;
    logic [7:0]  pre_addr, peek_addr;
    logic [11:0] pre_data, peek_data;
    logic [3:0]  opcode;
    logic        acc_neg, bus_clash;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sbus_datapath u_dut (
        .clk(clk), .rst(rst), .ctl_word(ctl_word), .pre_we(pre_we),
        .pre_addr(pre_addr), .pre_data(pre_data), .peek_addr(peek_addr),
        .peek_data(peek_data), .opcode(opcode), .acc_neg(acc_neg),
        .bus_clash(bus_clash)
    );

    task automatic check(input string tag, input logic [11:0] got,
                         input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic [15:0] w);
        @(negedge clk);
        ctl_word = w;
        @(posedge clk);
        #1 ctl_word = '0;
    endtask

    task automatic poke(input logic [7:0] a, input logic [11:0] d,
                        input logic [15:0] w);
        @(negedge clk);
        ctl_word = w; pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(posedge clk);
        #1 pre_we = 1'b0; ctl_word = '0;
    endtask

    task automatic peek_chk(input string tag, input logic [7:0] a,
                            input logic [11:0] exp);
        peek_addr = a;
        #1 check(tag, peek_data, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1; ctl_word = '0; pre_we = 1'b0;
        pre_addr = '0; pre_data = '0; peek_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 opcode after reset", {8'h0, opcode}, 12'h0);
        check("R1 acc_neg after reset", {11'h0, acc_neg}, 12'h0);
        check("R3 clash idle", {11'h0, bus_clash}, 12'h0);
        peek_chk("R1 memory cleared", 8'h33, 12'h000);
    endtask

    task automatic t_preload;
        poke(8'h50, 12'h123, LA);               // busy: ignored
        peek_chk("R11 preload ignored when busy", 8'h50, 12'h000);
        poke(8'h00, 12'h1A5, '0);
        poke(8'hA5, 12'h803, '0);
        poke(8'h01, 12'h003, '0);
        poke(8'h02, 12'h777, '0);
        peek_chk("R11 preload when idle", 8'h00, 12'h1A5);
    endtask

    task automatic t_fetch_load;
        cyc(EP | LM); cyc(RD); cyc(ED | LI | INC);
        check("R2 R10 opcode", {8'h0, opcode}, 12'h001);
        cyc(EI | LM); cyc(RD); cyc(ED | LA);
        check("R4 R10 acc_neg", {11'h0, acc_neg}, 12'h001);
        cyc(EI | LA); cyc(EA | LD); cyc(WR);
        peek_chk("R3 R6 IR zero-extended store", 8'hA5, 12'h0A5);
    endtask

    task automatic t_alu;
        cyc(EA | LB);                 // B = 0A5
        cyc(EP | LM); cyc(RD); cyc(ED | LA);   // MAR=1, ACC=003
        cyc(SUB); cyc(EU | LA);
        check("R7 R10 negative after sub", {11'h0, acc_neg}, 12'h001);
        cyc(EA | LD); cyc(WR);
        peek_chk("R7 sub wraps", 8'h01, 12'hF5E);
        cyc(ADD); cyc(EU | LA); cyc(EA | LD); cyc(WR);
        peek_chk("R7 add wraps", 8'h01, 12'h003);
    endtask

    task automatic t_ordering;
        cyc(INC);                     // PC = 2
        cyc(EP | LM | RD);            // read old MAR=1, MAR becomes 2
        cyc(ED | LA); cyc(EA | LD); cyc(WR);
        peek_chk("R5 R8 read uses old MAR", 8'h02, 12'h003);
        cyc(LP | EI | INC);           // PC = A5 + 1
        cyc(EP | LD); cyc(WR);
        peek_chk("R9 load then increment", 8'h02, 12'h0A6);
        cyc(EA | LD | RD); cyc(WR);
        peek_chk("R5 load MDR beats read", 8'h02, 12'h003);
    endtask

    task automatic t_bus;
        @(negedge clk);
        ctl_word = EP | EA | LD;
        #1 check("R3 clash flag", {11'h0, bus_clash}, 12'h001);
        @(posedge clk);
        #1 ctl_word = '0;
        cyc(WR);
        peek_chk("R3 PC wins priority", 8'h02, 12'h0A6);
        poke(8'h02, 12'h0FF, '0);
        cyc(RD); cyc(ED | LP | INC);  // PC = FF + 1 -> 00
        cyc(EP | LD); cyc(WR);
        peek_chk("R9 R8 PC wraps", 8'h02, 12'h000);
        poke(8'h02, 12'h555, '0);
        cyc(LD); cyc(WR);
        peek_chk("R3 empty bus reads zero", 8'h02, 12'h000);
    endtask

    initial begin
        t_reset();
        t_preload();
        t_fetch_load();
        t_alu();
        t_ordering();
        t_bus();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule